// File: doc/BRIEF.md
# Programmable AND / Fixed OR Logic Array with Three-State Pins

This block is a small programmable logic array. Several output sections share one bus of dedicated inputs. Each section owns a fixed group of product terms. The AND plane of every term is programmable, and the section's OR gate is hard-wired to that group alone. Each section also has one more programmable product term. That term drives the output enable of a three-state pin.

The resolved value of every pin is fed back into the AND plane. This feedback lets a section's output serve as a first-pass helper term for a function that needs more products than one section holds. It also lets a pin whose driver is disabled act as a plain input.

The term codes sit in configuration registers. A single-entry write port loads them. The logic path from inputs and pins to outputs is purely combinational.

Top module: `pal_device`

## Requirements
- R1: After reset, every term code holds the forced-0 pattern. All `oe_o` bits are 0 and no pin is driven, so an external driver sets every pin value.
- R2: A term code has two bits per literal. Bit 2k selects the true form of literal k and bit 2k+1 selects its complement. The term is the AND of all selected literals. Literal k < NIN is `in_i[k]`, and literal NIN+s is the resolved value of `pin_io[s]`.
- R3: A term code with no bits set evaluates to constant 1. Any literal pair with both bits set forces the term to constant 0.
- R4: The logic value of a section is the OR of its own NTERM sum terms only. Writing the terms of another section never changes it.
- R5: `oe_o[s]` equals the value of section s's enable term. When it is 1, `pin_io[s]` carries the section's logic value; when it is 0, the section leaves the pin undriven.
- R6: With its enable term at 0, a pin driven from outside is seen by the AND plane of any section through its feedback literal.
- R7: With the enable term programmed to constant 1, the pin is always driven, and its value still reaches other sections as a feedback literal.
- R8: A function with more than NTERM products can be completed across two sections. The first section's output is used as a helper literal in the second.
- R9: On a clock edge with `cfg_we` high, the code on `cfg_code` is stored at section `cfg_sec` and slot `cfg_slot`. Slots 0..NTERM-1 are sum terms and slot NTERM is the enable term. A write to a slot above NTERM or to a section index of NSEC or more changes nothing.
- R10: The pins and `oe_o` follow changes of `in_i` and of the pin values with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the configuration registers |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sec | input | SEC_W | Section index of the write |
| cfg_slot | input | SLOT_W | Term slot of the write (NTERM = enable term) |
| cfg_code | input | 2*(NIN+NSEC) | Term code to store |
| in_i | input | NIN | Dedicated input bus shared by all sections |
| pin_io | inout | NSEC | Three-state section pins |
| oe_o | output | NSEC | Observed output enable of each pin |

## Verification
The bench builds the array with four inputs, four sections and four terms per section. A four-input function therefore needs helper feedback once it has more than four products. This size also lets every pattern of the input bus be swept exhaustively. Four sections leave room for one section built as a helper pair, one pin used as an input and one reader of that pin, all at the same time. The three-bit slot field covers addresses past the enable slot, so out-of-range writes can be tried.

// File: rtl/pal_pkg.sv
package pal_pkg;

  // Two-bit selector for one literal inside a product-term code
  typedef enum logic [1:0] {
    LIT_OFF  = 2'b00,  // literal does not take part
    LIT_TRUE = 2'b01,  // true form
    LIT_COMP = 2'b10,  // complemented form
    LIT_KILL = 2'b11   // both forms: term can never be 1
  } lit_sel_e;

  function automatic logic lit_pass(input lit_sel_e sel, input logic x);
    logic r;
    case (sel)
      LIT_OFF:  r = 1'b1;
      LIT_TRUE: r = x;
      LIT_COMP: r = ~x;
      default:  r = 1'b0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/pal_cfg_regs.sv
module pal_cfg_regs #(
  parameter int NSEC   = 4,
  parameter int NSLOT  = 5,
  parameter int CW     = 24,
  parameter int SEC_W  = 2,
  parameter int SLOT_W = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        we,
  input  logic [SEC_W-1:0]            sec,
  input  logic [SLOT_W-1:0]           slot,
  input  logic [CW-1:0]               code,
  output logic [NSEC*NSLOT*CW-1:0]    cfg_flat
);

  localparam int NENT = NSEC * NSLOT;

  logic [NENT-1:0]  hit;
  logic [CW-1:0]    cfg_d [NENT];
  logic [CW-1:0]    cfg_q [NENT];

  for (genvar s = 0; s < NSEC; s++) begin : g_sec
    for (genvar t = 0; t < NSLOT; t++) begin : g_slot
      localparam int E = s * NSLOT + t;

      // next-state
      always_comb begin
        hit[E]   = we && (sec == SEC_W'(s)) && (slot == SLOT_W'(t));
        cfg_d[E] = code;
      end

      // register with clock enable; reset to the forced-0 pattern
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cfg_q[E] <= '1;
        end else if (hit[E]) begin
          cfg_q[E] <= cfg_d[E];
        end
      end

      assign cfg_flat[E*CW +: CW] = cfg_q[E];
    end
  end

endmodule

// File: rtl/pal_product_term.sv
module pal_product_term
  import pal_pkg::*;
#(
  parameter int L = 12
) (
  input  logic [2*L-1:0] code,
  input  logic [L-1:0]   lits,
  output logic           term
);

  logic [L-1:0] pass;

  for (genvar k = 0; k < L; k++) begin : g_lit
    always_comb begin
      pass[k] = lit_pass(lit_sel_e'(code[2*k +: 2]), lits[k]);
    end
  end

  assign term = &pass;

endmodule

// File: rtl/pal_section.sv
module pal_section #(
  parameter int L     = 12,
  parameter int NTERM = 4
) (
  input  logic [(NTERM+1)*2*L-1:0] codes,
  input  logic [L-1:0]             lits,
  output logic                     val,
  output logic                     oe
);

  localparam int CW = 2 * L;

  logic [NTERM:0] terms;

  for (genvar t = 0; t <= NTERM; t++) begin : g_term
    pal_product_term #(.L(L)) u_term (
      .code (codes[t*CW +: CW]),
      .lits (lits),
      .term (terms[t])
    );
  end

  // fixed OR over this section's own sum terms
  assign val = |terms[NTERM-1:0];
  // the extra term drives the pin enable
  assign oe  = terms[NTERM];

endmodule

// File: rtl/pal_device.sv
module pal_device #(
  parameter int NIN   = 8,
  parameter int NSEC  = 4,
  parameter int NTERM = 4,
  localparam int L      = NIN + NSEC,
  localparam int CW     = 2 * L,
  localparam int NSLOT  = NTERM + 1,
  localparam int SEC_W  = (NSEC > 1) ? $clog2(NSEC) : 1,
  localparam int SLOT_W = $clog2(NSLOT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [SEC_W-1:0]  cfg_sec,
  input  logic [SLOT_W-1:0] cfg_slot,
  input  logic [CW-1:0]     cfg_code,
  input  logic [NIN-1:0]    in_i,
  inout  wire  [NSEC-1:0]   pin_io,
  output logic [NSEC-1:0]   oe_o
);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync;
  logic       rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync <= 2'b00;
    end else begin
      rst_sync <= {rst_sync[0], 1'b1};
    end
  end

  assign rst_q = rst_sync[1];

  logic [NSEC*NSLOT*CW-1:0] cfg_flat;

  pal_cfg_regs #(
    .NSEC  (NSEC),
    .NSLOT (NSLOT),
    .CW    (CW),
    .SEC_W (SEC_W),
    .SLOT_W(SLOT_W)
  ) u_cfg (
    .clk     (clk),
    .rst_n   (rst_q),
    .we      (cfg_we),
    .sec     (cfg_sec),
    .slot    (cfg_slot),
    .code    (cfg_code),
    .cfg_flat(cfg_flat)
  );

  // literal bus: dedicated inputs low, resolved pin feedback high
  logic [L-1:0]    lits;
  logic [NSEC-1:0] sec_val;

  assign lits = {pin_io, in_i};

  for (genvar s = 0; s < NSEC; s++) begin : g_sec
    pal_section #(.L(L), .NTERM(NTERM)) u_sec (
      .codes(cfg_flat[s*NSLOT*CW +: NSLOT*CW]),
      .lits (lits),
      .val  (sec_val[s]),
      .oe   (oe_o[s])
    );

    assign pin_io[s] = oe_o[s] ? sec_val[s] : 1'bz;
  end

endmodule

// File: rtl/pal_device_chk.sv
module pal_device_chk #(
  parameter int NIN   = 8,
  parameter int NSEC  = 4,
  parameter int NTERM = 4,
  localparam int L      = NIN + NSEC,
  localparam int CW     = 2 * L,
  localparam int NSLOT  = NTERM + 1,
  localparam int SEC_W  = (NSEC > 1) ? $clog2(NSEC) : 1,
  localparam int SLOT_W = $clog2(NSLOT)
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     cfg_we,
  input logic [SEC_W-1:0]         cfg_sec,
  input logic [SLOT_W-1:0]        cfg_slot,
  input logic [CW-1:0]            cfg_code,
  input logic [NSEC*NSLOT*CW-1:0] cfg_flat,
  input logic [NSEC-1:0]          sec_val,
  input logic [NSEC-1:0]          oe_o,
  input logic [NSEC-1:0]          pin_io
);

  function automatic logic any_kill(input logic [CW-1:0] c);
    logic r;
    r = 1'b0;
    for (int k = 0; k < L; k++) begin
      r = r | (c[2*k] & c[2*k+1]);
    end
    return r;
  endfunction

  logic wr_ok;
  assign wr_ok = cfg_we && (int'(cfg_sec) < NSEC) && (int'(cfg_slot) <= NTERM);

  // R9: valid write lands in the addressed entry
  assert_cfg_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ok |=> cfg_flat[(int'($past(cfg_sec)) * NSLOT + int'($past(cfg_slot))) * CW +: CW]
              == $past(cfg_code));

  // R9: no write or an out-of-range write leaves every entry unchanged
  assert_cfg_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ok |=> $stable(cfg_flat));

  for (genvar s = 0; s < NSEC; s++) begin : g_sec
    logic [CW-1:0] oe_code;
    assign oe_code = cfg_flat[(s*NSLOT + NTERM)*CW +: CW];

    // R5: an enabled pin carries the section's logic value
    assert_pin_drive_R5: assert property (@(posedge clk) disable iff (!rst_n)
      oe_o[s] |-> (pin_io[s] == sec_val[s]));

    // R3: empty enable code gives constant 1
    assert_oe_const1_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (oe_code == '0) |-> oe_o[s]);

    // R3: a killed literal pair gives constant 0
    assert_oe_const0_R3: assert property (@(posedge clk) disable iff (!rst_n)
      any_kill(oe_code) |-> !oe_o[s]);
  end

endmodule

bind pal_device pal_device_chk #(
  .NIN  (NIN),
  .NSEC (NSEC),
  .NTERM(NTERM)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_q),
  .cfg_we  (cfg_we),
  .cfg_sec (cfg_sec),
  .cfg_slot(cfg_slot),
  .cfg_code(cfg_code),
  .cfg_flat(cfg_flat),
  .sec_val (sec_val),
  .oe_o    (oe_o),
  .pin_io  (pin_io)
);

// File: tb/pal_device_tb.sv
`timescale 1ns/1ps
module pal_device_tb;

  localparam int NIN    = 4;
  localparam int NSEC   = 4;
  localparam int NTERM  = 4;
  localparam int L      = NIN + NSEC;
  localparam int CW     = 2 * L;
  localparam int SEC_W  = 2;
  localparam int SLOT_W = 3;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              cfg_we;
  logic [SEC_W-1:0]  cfg_sec;
  logic [SLOT_W-1:0] cfg_slot;
  logic [CW-1:0]     cfg_code;
  logic [NIN-1:0]    in_i;
  wire  [NSEC-1:0]   pin;
  logic [NSEC-1:0]   oe_o;
  logic [NSEC-1:0]   tb_en;
  logic [NSEC-1:0]   tb_val;

  int n_run  = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  for (genvar s = 0; s < NSEC; s++) begin : g_drv
    assign pin[s] = tb_en[s] ? tb_val[s] : 1'bz;
  end

  pal_device #(.NIN(NIN), .NSEC(NSEC), .NTERM(NTERM)) u_dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .cfg_we  (cfg_we),
    .cfg_sec (cfg_sec),
    .cfg_slot(cfg_slot),
    .cfg_code(cfg_code),
    .in_i    (in_i),
    .pin_io  (pin),
    .oe_o    (oe_o)
  );

  // code helpers (R2 encoding: bit 2k true, bit 2k+1 complement)
  localparam logic [CW-1:0] C_ONE  = '0;
  localparam logic [CW-1:0] C_KILL = CW'(2'b11);

  function automatic logic [CW-1:0] lt(input int k);
    return CW'(1) << (2*k);
  endfunction

  function automatic logic [CW-1:0] lc(input int k);
    return CW'(1) << (2*k + 1);
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic wr(input int s, input int t, input logic [CW-1:0] c);
    @(negedge clk);
    cfg_we   = 1'b1;
    cfg_sec  = SEC_W'(s);
    cfg_slot = SLOT_W'(t);
    cfg_code = c;
    @(negedge clk);
    cfg_we   = 1'b0;
  endtask

  task automatic kill_all();
    for (int s = 0; s < NSEC; s++)
      for (int t = 0; t <= NTERM; t++)
        wr(s, t, C_KILL);
  endtask

  task automatic t_reset();
    check("R1 oe after reset", 32'(oe_o), 32'h0);
    tb_en  = '1;
    tb_val = 4'b1010;
    #1;
    check("R1 pins undriven after reset", 32'(pin), 32'ha);
    tb_val = 4'b0101;
    #1;
    check("R1 pins undriven after reset", 32'(pin), 32'h5);
    tb_en  = '0;
  endtask

  task automatic t_hiz_and_input();
    kill_all();
    // section 2: value constant 1, enable killed
    wr(2, 0, C_ONE);
    // section 3: reads pin 2 feedback, always enabled (R7)
    wr(3, 0, lt(NIN + 2));
    wr(3, NTERM, C_ONE);
    tb_en[2] = 1'b1; tb_val[2] = 1'b0; in_i = '0;
    #1;
    check("R5 oe off", 32'(oe_o[2]), 32'h0);
    check("R5 pin Hi-Z yields to outside 0", 32'(pin[2]), 32'h0);
    check("R6 outside 0 seen by feedback", 32'(pin[3]), 32'h0);
    tb_val[2] = 1'b1;
    #1;
    check("R6 outside 1 seen by feedback", 32'(pin[3]), 32'h1);
    check("R7 const enable", 32'(oe_o[3]), 32'h1);
    // enable follows in_i[0]
    wr(2, NTERM, lt(0));
    tb_en[2] = 1'b0;
    in_i = 4'b0001;
    #1;
    check("R5 oe on", 32'(oe_o[2]), 32'h1);
    check("R5 driven value", 32'(pin[2]), 32'h1);
    check("R7 driven value fed back", 32'(pin[3]), 32'h1);
    in_i = 4'b0000;
    #1;
    check("R10 oe drops without clock", 32'(oe_o[2]), 32'h0);
    tb_en[2] = 1'b1; tb_val[2] = 1'b0;
    #1;
    check("R5 pin released again", 32'(pin[2]), 32'h0);
    tb_en = '0;
  endtask

  task automatic t_const_terms();
    kill_all();
    wr(1, NTERM, C_ONE);
    #1;
    check("R3 killed sum terms give 0", 32'(pin[1]), 32'h0);
    wr(1, 2, C_ONE);
    #1;
    check("R3 empty term gives 1", 32'(pin[1]), 32'h1);
    wr(1, 2, lt(1) | lc(3) | lt(3));
    in_i = 4'b0010;
    #1;
    check("R3 killed pair beats true literals", 32'(pin[1]), 32'h0);
    wr(1, 2, lt(1) | lc(3));
    for (int v = 0; v < 16; v++) begin
      in_i = 4'(v);
      #1;
      check("R2 term in1 & ~in3", 32'(pin[1]), 32'(in_i[1] & ~in_i[3]));
    end
  endtask

  task automatic t_helper();
    kill_all();
    // section 0: ab + ac + ad + bc
    wr(0, 0, lt(0) | lt(1));
    wr(0, 1, lt(0) | lt(2));
    wr(0, 2, lt(0) | lt(3));
    wr(0, 3, lt(1) | lt(2));
    wr(0, NTERM, C_ONE);
    // section 1: helper + bd + cd
    wr(1, 0, lt(NIN + 0));
    wr(1, 1, lt(1) | lt(3));
    wr(1, 2, lt(2) | lt(3));
    wr(1, NTERM, C_ONE);
    for (int v = 0; v < 16; v++) begin
      logic a, b, c, d;
      in_i = 4'(v);
      {d, c, b, a} = 4'(v);
      #1;
      check("R8 helper section", 32'(pin[0]), 32'((a&b)|(a&c)|(a&d)|(b&c)));
      check("R8 six-product result", 32'(pin[1]), 32'($countones(4'(v)) >= 2));
    end
  endtask

  task automatic t_no_share();
    // section 0 keeps its function while section 1 and 2 are rewritten
    wr(1, 3, C_ONE);
    wr(2, 0, C_ONE);
    wr(2, NTERM, C_ONE);
    for (int v = 0; v < 16; v++) begin
      logic a, b, c, d;
      in_i = 4'(v);
      {d, c, b, a} = 4'(v);
      #1;
      check("R4 no sharing", 32'(pin[0]), 32'((a&b)|(a&c)|(a&d)|(b&c)));
    end
  endtask

  task automatic t_bad_slot();
    in_i = 4'b0000;
    wr(0, 5, C_ONE);
    wr(0, 7, C_ONE);
    #1;
    check("R9 slot past enable ignored", 32'(pin[0]), 32'h0);
    check("R9 enable unchanged", 32'(oe_o[0]), 32'h1);
    wr(0, 0, C_ONE);
    #1;
    check("R9 valid write applied", 32'(pin[0]), 32'h1);
  endtask

  initial begin
    #(200000 * 4);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_sec = '0; cfg_slot = '0; cfg_code = '0;
    in_i = '0; tb_en = '0; tb_val = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_hiz_and_input();
    t_const_terms();
    t_helper();
    t_no_share();
    t_bad_slot();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule